// File: doc/BRIEF.md
# Dual-CPU Doorbell Interrupt Mailbox

This block lets two processors raise interrupts on each other through a small memory-mapped window. Each processor owns a 4-bit pending word. Any agent on the register bus changes the word by writing a mask to a write-one-to-set register or to a write-one-to-clear register. The current value is read back from a read-only status register. The interrupt line of each processor is high exactly while its word holds a non-zero value. A read-only block of twelve identification bytes sits at the top of the 4 KB window.

The bus is a single-cycle strobe interface. While `req` is high for one clock, the block takes the address, the write enable and the write data at that clock edge. The read data and the error flag are registered, so they are valid during the cycle that follows the accepted request. When no request was accepted, both are zero.

Top module: `dbell_mailbox`

## Requirements
- R1: While reset is held, and after it is released, both pending words are zero, both interrupt outputs are low, and `rdata` and `err` are zero.
- R2: A write to a set register (CPU A at offset 0x004, CPU B at offset 0x014) ORs `wdata[3:0]` into that CPU's word. Bits 31:4 of the write data are ignored.
- R3: A write to a clear register (CPU A at 0x008, CPU B at 0x018) clears each bit of the word for which `wdata[3:0]` holds a 1. Other bits are unchanged.
- R4: Each interrupt output (`irq_a`, `irq_b`) is high exactly when its word is non-zero. It takes its new level at the same clock edge that accepts the write.
- R5: A read of a status register (CPU A at 0x000, CPU B at 0x010) returns the word in bits 3:0 with zeros above, in the cycle after the request, with `err` low.
- R6: A read of any set or clear register returns 0 and raises `err` for one cycle.
- R7: A write to a status register or to an identification register changes no state and raises `err` for one cycle.
- R8: Reads of the twelve word-aligned offsets 0xFD0 to 0xFFC return, in address order, 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1, with `err` low.
- R9: An access to an unlisted offset, or to an address with bits 1:0 non-zero, reads 0, changes no state and raises `err` for one cycle.
- R10: An access to one CPU's registers never changes the other CPU's word or interrupt line.
- R11: In a cycle that follows no accepted request, `rdata` and `err` are both zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset within the 4 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after the request |
| err | output | 1 | Access error, high for one cycle after a bad access |
| irq_a | output | 1 | Level interrupt for CPU A |
| irq_b | output | 1 | Level interrupt for CPU B |

## Verification
The properties assume that every access lasts exactly one `req` cycle. They also assume that `addr`, `we` and `wdata` are stable across the clock edge that samples them. That is why a property can tie the response in the next cycle to the request in the cycle before it. The bench keeps to these assumptions: it changes the inputs only on the falling edge, and it drops `req` between accesses. It also issues bad-offset, misaligned and wrong-direction accesses. Each of these is followed by a status read, so that a state change the access should not have made shows up at the ports.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int DB_ADDR_W   = 12;
    localparam int DB_DATA_W   = 32;
    localparam int DB_BELL_W   = 4;
    localparam int DB_NUM_CPU  = 2;
    localparam int DB_ID_COUNT = 12;

    // Offsets inside the window; CPU B is CPU A plus the stride.
    localparam logic [DB_ADDR_W-1:0] OFS_STAT_A = 12'h000;
    localparam logic [DB_ADDR_W-1:0] OFS_SET_A  = 12'h004;
    localparam logic [DB_ADDR_W-1:0] OFS_CLR_A  = 12'h008;
    localparam logic [DB_ADDR_W-1:0] OFS_STAT_B = 12'h010;
    localparam logic [DB_ADDR_W-1:0] OFS_SET_B  = 12'h014;
    localparam logic [DB_ADDR_W-1:0] OFS_CLR_B  = 12'h018;
    localparam logic [DB_ADDR_W-1:0] OFS_ID_LO  = 12'hFD0;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_STAT,
        RG_SET,
        RG_CLR,
        RG_ID
    } region_e;

    typedef struct packed {
        region_e    kind;
        logic       cpu;
        logic [3:0] id_idx;
    } decode_t;

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        logic [7:0] v;
        case (idx)
            4'd0:    v = 8'h04;
            4'd4:    v = 8'h56;
            4'd5:    v = 8'hB8;
            4'd6:    v = 8'h0B;
            4'd8:    v = 8'h0D;
            4'd9:    v = 8'hF0;
            4'd10:   v = 8'h05;
            4'd11:   v = 8'hB1;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
    import dbell_pkg::*;
#(
    parameter int ADDR_W   = DB_ADDR_W,
    parameter int ID_COUNT = DB_ID_COUNT
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    localparam logic [ADDR_W-1:0] ID_BASE = ADDR_W'((1 << ADDR_W) - 4 * ID_COUNT);

    always_comb begin
        dec        = '0;
        dec.kind   = RG_NONE;
        if (addr[1:0] != 2'b00) begin
            dec.kind = RG_NONE;
        end else if (addr >= ID_BASE) begin
            dec.kind   = RG_ID;
            dec.id_idx = addr[5:2] - ID_BASE[5:2];
        end else if (addr[ADDR_W-1:5] == '0) begin
            dec.cpu = addr[4];
            case (addr[3:2])
                2'd0:    dec.kind = RG_STAT;
                2'd1:    dec.kind = RG_SET;
                2'd2:    dec.kind = RG_CLR;
                default: dec.kind = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/dbell_word.sv
module dbell_word #(
    parameter int BELL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [BELL_W-1:0] mask,
    output logic [BELL_W-1:0] word,
    output logic              irq
);
    logic [BELL_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (set_en) word_d = word_q | mask;
        if (clr_en) word_d = word_d & ~mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word = word_q;
    assign irq  = |word_q;
endmodule

// File: rtl/dbell_id_rom.sv
module dbell_id_rom
    import dbell_pkg::*;
#(
    parameter int DATA_W = DB_DATA_W
) (
    input  logic [3:0]        idx,
    output logic [DATA_W-1:0] value
);
    always_comb value = DATA_W'(id_byte(idx));
endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox
    import dbell_pkg::*;
#(
    parameter int ADDR_W = DB_ADDR_W,
    parameter int DATA_W = DB_DATA_W,
    parameter int BELL_W = DB_BELL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err,
    output logic              irq_a,
    output logic              irq_b
);
    localparam int NUM_CPU = DB_NUM_CPU;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } resp_t;

    decode_t           dec;
    logic [BELL_W-1:0] word [NUM_CPU];
    logic [NUM_CPU-1:0] irq;
    logic [DATA_W-1:0] id_val;
    resp_t             resp_d, resp_q;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:BELL_W];

    dbell_decode #(.ADDR_W(ADDR_W), .ID_COUNT(DB_ID_COUNT)) i_decode (
        .addr (addr),
        .dec  (dec)
    );

    dbell_id_rom #(.DATA_W(DATA_W)) i_id_rom (
        .idx   (dec.id_idx),
        .value (id_val)
    );

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
        logic hit;
        assign hit = req && we && (dec.cpu == 1'(g));
        dbell_word #(.BELL_W(BELL_W)) i_word (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (hit && dec.kind == RG_SET),
            .clr_en (hit && dec.kind == RG_CLR),
            .mask   (wdata[BELL_W-1:0]),
            .word   (word[g]),
            .irq    (irq[g])
        );
    end

    always_comb begin
        resp_d = '0;
        if (req) begin
            case (dec.kind)
                RG_STAT: begin
                    if (we) resp_d.err   = 1'b1;
                    else    resp_d.rdata = DATA_W'(word[dec.cpu]);
                end
                RG_SET, RG_CLR: begin
                    if (!we) resp_d.err = 1'b1;
                end
                RG_ID: begin
                    if (we) resp_d.err   = 1'b1;
                    else    resp_d.rdata = id_val;
                end
                default: resp_d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign rdata = resp_q.rdata;
    assign err   = resp_q.err;
    assign irq_a = irq[0];
    assign irq_b = irq[1];
endmodule

// File: rtl/dbell_mailbox_chk.sv
module dbell_mailbox_chk
    import dbell_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req,
    input logic                 we,
    input logic [DB_ADDR_W-1:0] addr,
    input logic [DB_DATA_W-1:0] wdata,
    input logic [DB_DATA_W-1:0] rdata,
    input logic                 err,
    input logic                 irq_a,
    input logic                 irq_b
);
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DB_DATA_W-1:DB_BELL_W];

    p_set_raises_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req && we && addr == OFS_SET_A && wdata[3:0] != 4'h0 |=> irq_a);

    p_clear_all_drops_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req && we && addr == OFS_CLR_A && wdata[3:0] == 4'hF |=> !irq_a);

    p_wo_read_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req && !we && (addr == OFS_SET_A || addr == OFS_CLR_A ||
                       addr == OFS_SET_B || addr == OFS_CLR_B)
        |=> err && rdata == '0);

    p_id_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req && !we && addr == OFS_ID_LO + 12'h010 |=> !err && rdata == 32'h56);

    p_misaligned_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req && addr[1:0] != 2'b00 |=> err && rdata == '0);

    p_irq_b_isolated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && we && (addr == OFS_SET_B || addr == OFS_CLR_B)) |=> $stable(irq_b));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !err && rdata == '0);
endmodule

bind dbell_mailbox dbell_mailbox_chk i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .we    (we),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .err   (err),
    .irq_a (irq_a),
    .irq_b (irq_b)
);

// File: tb/test_dbell_mailbox.sv
module test_dbell_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    logic        irq_a, irq_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] rd;
        logic        er;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    dbell_mailbox i_dbell_mailbox (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .err(err), .irq_a(irq_a), .irq_b(irq_b)
    );

    // Monitor: pops one expected response per accepted request.
    initial begin
        forever begin
            bit had;
            @(posedge clk);
            had = req && rst_n;
            @(negedge clk);
            if (had) begin
                exp_t e;
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL scoreboard: response with empty queue");
                end else begin
                    e = sb.pop_front();
                    checks++;
                    if (rdata !== e.rd || err !== e.er) begin
                        errors++;
                        $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                                 e.tag, rdata, err, e.rd, e.er);
                    end
                end
            end
        end
    end

    task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d,
                          input logic [31:0] exp_rd, input logic exp_er, input string tag);
        exp_t e;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        e.rd = exp_rd; e.er = exp_er; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req = 1'b0; we = 1'b0; wdata = '0;
    endtask

    task automatic chk_irq(input logic ea, input logic eb, input string tag);
        checks++;
        if (irq_a !== ea || irq_b !== eb) begin
            errors++;
            $display("FAIL %s: irq_a=%b irq_b=%b expected irq_a=%b irq_b=%b",
                     tag, irq_a, irq_b, ea, eb);
        end
    endtask

    task automatic chk_idle(input string tag);
        checks++;
        if (rdata !== 32'h0 || err !== 1'b0) begin
            errors++;
            $display("FAIL %s: rdata=%h err=%b expected rdata=0 err=0", tag, rdata, err);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_irq(1'b0, 1'b0, "R1 in reset");
        chk_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_irq(1'b0, 1'b0, "R1 after reset");
        access(1'b0, 12'h000, 0, 32'h0, 1'b0, "R1 status A zero");
        access(1'b0, 12'h010, 0, 32'h0, 1'b0, "R1 status B zero");
        @(negedge clk);
        chk_idle("R11 idle");

        access(1'b1, 12'h004, 32'h5, 32'h0, 1'b0, "R2 set A");
        chk_irq(1'b1, 1'b0, "R4 irq after set A / R10");
        access(1'b0, 12'h000, 0, 32'h5, 1'b0, "R5 status A");
        access(1'b1, 12'h004, 32'hFFFF_FFF2, 32'h0, 1'b0, "R2 set A masked");
        access(1'b0, 12'h000, 0, 32'h7, 1'b0, "R2 status A after mask");
        access(1'b1, 12'h008, 32'hABCD_0003, 32'h0, 1'b0, "R3 clear A");
        access(1'b0, 12'h000, 0, 32'h4, 1'b0, "R3 status A after clear");
        chk_irq(1'b1, 1'b0, "R4 irq stays with bit 2");
        access(1'b1, 12'h008, 32'h4, 32'h0, 1'b0, "R3 clear last bit");
        chk_irq(1'b0, 1'b0, "R4 irq drops at zero");

        access(1'b1, 12'h014, 32'h8, 32'h0, 1'b0, "R2 set B");
        chk_irq(1'b0, 1'b1, "R10 only irq_b rises");
        access(1'b0, 12'h010, 0, 32'h8, 1'b0, "R5 status B");
        access(1'b0, 12'h000, 0, 32'h0, 1'b0, "R10 status A untouched");

        access(1'b0, 12'h014, 0, 32'h0, 1'b1, "R6 read set B");
        access(1'b0, 12'h008, 0, 32'h0, 1'b1, "R6 read clear A");
        access(1'b0, 12'h004, 0, 32'h0, 1'b1, "R6 read set A");
        access(1'b0, 12'h018, 0, 32'h0, 1'b1, "R6 read clear B");

        access(1'b1, 12'h010, 32'hF, 32'h0, 1'b1, "R7 write status B");
        access(1'b0, 12'h010, 0, 32'h8, 1'b0, "R7 status B unchanged");
        access(1'b1, 12'h000, 32'hF, 32'h0, 1'b1, "R7 write status A");
        chk_irq(1'b0, 1'b1, "R7 irq unchanged");
        access(1'b1, 12'hFE0, 32'hFF, 32'h0, 1'b1, "R7 write ID");
        access(1'b0, 12'hFE0, 0, 32'h56, 1'b0, "R7 ID unchanged");

        begin
            logic [7:0] idv [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h56, 8'hB8,
                                     8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
            for (int i = 0; i < 12; i++)
                access(1'b0, 12'hFD0 + 12'(4 * i), 0, {24'h0, idv[i]}, 1'b0, "R8 ID byte");
        end

        access(1'b0, 12'h020, 0, 32'h0, 1'b1, "R9 read unlisted");
        access(1'b1, 12'h00C, 32'hF, 32'h0, 1'b1, "R9 write unlisted");
        access(1'b1, 12'h1C, 32'hF, 32'h0, 1'b1, "R9 write unlisted B side");
        access(1'b1, 12'h005, 32'hF, 32'h0, 1'b1, "R9 misaligned set A");
        access(1'b1, 12'h016, 32'hF, 32'h0, 1'b1, "R9 misaligned set B");
        access(1'b0, 12'h000, 0, 32'h0, 1'b0, "R9 status A unchanged");
        access(1'b0, 12'h010, 0, 32'h8, 1'b0, "R9 status B unchanged");
        access(1'b0, 12'hFD2, 0, 32'h0, 1'b1, "R9 misaligned ID read");
        @(negedge clk);
        chk_idle("R11 idle after error");

        access(1'b1, 12'h018, 32'hF, 32'h0, 1'b0, "R3 clear B all");
        chk_irq(1'b0, 1'b0, "R4 irq_b drops");

        access(1'b1, 12'h004, 32'h3, 32'h0, 1'b0, "R2 set A before reset");
        access(1'b1, 12'h014, 32'h1, 32'h0, 1'b0, "R2 set B before reset");
        chk_irq(1'b1, 1'b1, "R4 both irq high");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_irq(1'b0, 1'b0, "R1 reset clears irq");
        rst_n = 1'b1;
        access(1'b0, 12'h000, 0, 32'h0, 1'b0, "R1 status A after reset");
        access(1'b0, 12'h010, 0, 32'h0, 1'b0, "R1 status B after reset");

        repeat (2) @(negedge clk);
        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: %0d responses missing, expected 0", sb.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule